// File: doc/BRIEF.md
# Bank-Group Burst Interleave Scheduler

This block chooses the issue cycle of each read or write column command for one rank. It also keeps the earliest cycle at which the next column command may follow. It is built for long bursts that go out as two sub-bursts with a hole between them. A burst to a different bank group may drop into that hole, after only the short sub-burst spacing. A second such drop straight after the first is never allowed. A command that would land inside the previous burst without sitting exactly on the hole is pushed to the end of the full burst.

The caller gives each command an absolute earliest cycle, its direction and its bank group. One cycle later the block returns the issue cycle and the cycle at which read data is ready. At the same time it updates a rank-wide next-burst cycle and a pair of earliest-read and earliest-write cycles for every bank group. Those cycles include column-to-column spacing and the turnaround penalties between reads and writes. All timing values arrive in clock cycles on configuration inputs and are held steady outside reset.

Top module: `ilv_sched`

## Requirements
- R1: While rst_ni is low and after its release, every output is zero until the first accepted command.
- R2: A command presented with cmd_valid_i high is reported one cycle later, with issue_valid_o high for that single cycle. Its candidate cycle is the largest of cmd_req_cycle_i, the current next-burst cycle and the selected bank group's earliest cycle for the command's direction (cmd_is_read_i = 1 for read, 0 for write). The issue cycle is this candidate unless R4 or R5 moves it.
- R3: Interleaving is active only when cfg_t_burst_min_i differs from cfg_t_burst_i. When inactive, the issue cycle is always the candidate and the gap is cfg_t_burst_i.
- R4: With interleaving active, a candidate that equals the previous issue cycle plus cfg_t_burst_min_i issues there, and the gap to the next burst becomes cfg_t_burst_i. Two short spacings therefore never occur back to back.
- R5: With interleaving active, any other candidate below the previous issue cycle plus cfg_t_burst_i is moved to exactly that sum, with the short gap cfg_t_burst_min_i.
- R6: The first command after reset has no previous burst and is never moved. Its gap is cfg_t_burst_min_i.
- R7: next_burst_o becomes the issue cycle plus the chosen gap, and ready_cycle_o becomes the issue cycle plus cfg_t_cl_i plus cfg_t_burst_i.
- R8: For the bank group of the command, the following spacings are added to the issue cycle. A read gives cfg_t_ccd_l_i to the next read, and the larger of cfg_t_ccd_l_i and cfg_t_rtw_i + cfg_t_burst_max_i to the next write. A write gives cfg_t_ccd_l_i to the next write, and the larger of cfg_t_ccd_l_i and cfg_t_cl_i + cfg_t_burst_max_i + cfg_t_wtr_l_i to the next read.
- R9: For every other bank group, the following spacings are added to the issue cycle. Same-direction commands get the chosen gap. A read-to-write pair gets cfg_t_rtw_i + cfg_t_burst_i. A write-to-read pair gets cfg_t_cl_i + cfg_t_burst_i + cfg_t_wtr_i.
- R10: Per-bank-group earliest cycles never decrease. Each is updated to the larger of its old value and the new bound.
- R11: A cycle with cmd_valid_i low changes no state. issue_valid_o is low in the following cycle and all cycle outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_t_burst_i | input | TIM_W | Nominal burst duration |
| cfg_t_burst_min_i | input | TIM_W | Minimum (interleave) spacing between bursts |
| cfg_t_burst_max_i | input | TIM_W | Same-bank-group column access delay |
| cfg_t_ccd_l_i | input | TIM_W | Same-bank-group column-to-column spacing |
| cfg_t_cl_i | input | TIM_W | Read latency |
| cfg_t_wtr_i | input | TIM_W | Write-to-read penalty, other bank group |
| cfg_t_wtr_l_i | input | TIM_W | Write-to-read penalty, same bank group |
| cfg_t_rtw_i | input | TIM_W | Read-to-write penalty |
| cmd_valid_i | input | 1 | Column command present this cycle |
| cmd_is_read_i | input | 1 | 1 = read, 0 = write |
| cmd_bank_group_i | input | BG_W | Target bank group |
| cmd_req_cycle_i | input | CYC_W | Earliest cycle the caller wants |
| issue_valid_o | output | 1 | Issue result valid (one cycle after cmd_valid_i) |
| issue_cycle_o | output | CYC_W | Chosen issue cycle |
| ready_cycle_o | output | CYC_W | Cycle at which data is ready |
| next_burst_o | output | CYC_W | Earliest cycle for the next column command of the rank |
| rd_allowed_o | output | NUM_BG*CYC_W | Earliest read cycle per bank group, group g at bits g*CYC_W |
| wr_allowed_o | output | NUM_BG*CYC_W | Earliest write cycle per bank group, group g at bits g*CYC_W |

## Verification
The bench goes after the hole: a burst to another group that lands exactly on the short spacing, and the one after it. A design that keeps interleaving would let the follower issue a second short gap and collide on the data bus. A candidate sitting strictly inside the previous burst is also driven. A design that fails to snap it overlaps data, and one that snaps to the wrong edge wastes cycles. Other cases are the first command after reset, which a careless design snaps against a phantom burst at cycle zero, and writes followed by reads in the same and in another group. Swapping the same-group and other-group penalties shows up directly on the allowed cycles. A run with equal nominal and minimum spacing then confirms that the interleave rules drop out.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;
  typedef enum logic {GAP_MIN = 1'b0, GAP_FULL = 1'b1} gap_e;
endpackage

// File: rtl/ilv_slot_pick.sv
module ilv_slot_pick
  import ilv_pkg::*;
#(
  parameter int CYC_W = 32,
  parameter int TIM_W = 8
) (
  input  logic [CYC_W-1:0] req_cycle_i,
  input  logic [CYC_W-1:0] col_allowed_i,
  input  logic [CYC_W-1:0] next_burst_i,
  input  logic [CYC_W-1:0] last_burst_i,
  input  logic             have_last_i,
  input  logic [TIM_W-1:0] t_burst_i,
  input  logic [TIM_W-1:0] t_burst_min_i,
  output logic [CYC_W-1:0] cmd_at_o,
  output logic [CYC_W-1:0] gap_o
);
  logic [CYC_W-1:0] base_at;
  logic [CYC_W-1:0] hole_at;
  logic [CYC_W-1:0] full_at;
  logic             ilv_en;
  gap_e             gap_sel;

  always_comb begin
    base_at = req_cycle_i;
    if (col_allowed_i > base_at) base_at = col_allowed_i;
    if (next_burst_i > base_at)  base_at = next_burst_i;
  end

  assign hole_at = last_burst_i + CYC_W'(t_burst_min_i);
  assign full_at = last_burst_i + CYC_W'(t_burst_i);
  assign ilv_en  = (t_burst_i != t_burst_min_i);

  always_comb begin
    cmd_at_o = base_at;
    gap_sel  = GAP_MIN;
    if (ilv_en && have_last_i) begin
      if (base_at == hole_at) begin
        gap_sel = GAP_FULL;        // already inside the hole: no second short gap
      end else if (base_at < full_at) begin
        cmd_at_o = full_at;        // off-boundary: snap to end of full burst
      end
    end
  end

  assign gap_o = (gap_sel == GAP_FULL) ? CYC_W'(t_burst_i) : CYC_W'(t_burst_min_i);
endmodule

// File: rtl/ilv_turn_calc.sv
module ilv_turn_calc
  import ilv_pkg::*;
#(
  parameter int CYC_W = 32,
  parameter int TIM_W = 8
) (
  input  dir_e             dir_i,
  input  logic [CYC_W-1:0] gap_i,
  input  logic [TIM_W-1:0] t_burst_i,
  input  logic [TIM_W-1:0] t_burst_max_i,
  input  logic [TIM_W-1:0] t_ccd_l_i,
  input  logic [TIM_W-1:0] t_cl_i,
  input  logic [TIM_W-1:0] t_wtr_i,
  input  logic [TIM_W-1:0] t_wtr_l_i,
  input  logic [TIM_W-1:0] t_rtw_i,
  output logic [CYC_W-1:0] same_rd_o,
  output logic [CYC_W-1:0] same_wr_o,
  output logic [CYC_W-1:0] diff_rd_o,
  output logic [CYC_W-1:0] diff_wr_o
);
  logic [CYC_W-1:0] ccd_l;
  logic [CYC_W-1:0] wtr_same;
  logic [CYC_W-1:0] rtw_same;
  logic [CYC_W-1:0] wtr_diff;
  logic [CYC_W-1:0] rtw_diff;

  assign ccd_l    = CYC_W'(t_ccd_l_i);
  assign wtr_same = CYC_W'(t_cl_i) + CYC_W'(t_burst_max_i) + CYC_W'(t_wtr_l_i);
  assign rtw_same = CYC_W'(t_rtw_i) + CYC_W'(t_burst_max_i);
  assign wtr_diff = CYC_W'(t_cl_i) + CYC_W'(t_burst_i) + CYC_W'(t_wtr_i);
  assign rtw_diff = CYC_W'(t_rtw_i) + CYC_W'(t_burst_i);

  always_comb begin
    if (dir_i == DIR_RD) begin
      same_rd_o = ccd_l;
      same_wr_o = (rtw_same > ccd_l) ? rtw_same : ccd_l;
      diff_rd_o = gap_i;
      diff_wr_o = rtw_diff;
    end else begin
      same_rd_o = (wtr_same > ccd_l) ? wtr_same : ccd_l;
      same_wr_o = ccd_l;
      diff_rd_o = wtr_diff;
      diff_wr_o = gap_i;
    end
  end
endmodule

// File: rtl/ilv_bg_timer.sv
module ilv_bg_timer #(
  parameter int CYC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             same_i,
  input  logic [CYC_W-1:0] cmd_at_i,
  input  logic [CYC_W-1:0] same_rd_i,
  input  logic [CYC_W-1:0] same_wr_i,
  input  logic [CYC_W-1:0] diff_rd_i,
  input  logic [CYC_W-1:0] diff_wr_i,
  output logic [CYC_W-1:0] rd_allowed_o,
  output logic [CYC_W-1:0] wr_allowed_o
);
  logic [CYC_W-1:0] rd_q, wr_q;
  logic [CYC_W-1:0] rd_cand, wr_cand;

  assign rd_cand = cmd_at_i + (same_i ? same_rd_i : diff_rd_i);
  assign wr_cand = cmd_at_i + (same_i ? same_wr_i : diff_wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (upd_i) begin
      if (rd_cand > rd_q) rd_q <= rd_cand;
      if (wr_cand > wr_q) wr_q <= wr_cand;
    end
  end

  assign rd_allowed_o = rd_q;
  assign wr_allowed_o = wr_q;
endmodule

// File: rtl/ilv_sched.sv
module ilv_sched
  import ilv_pkg::*;
#(
  parameter int CYC_W  = 32,
  parameter int TIM_W  = 8,
  parameter int NUM_BG = 4,
  localparam int BG_W  = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TIM_W-1:0]        cfg_t_burst_i,
  input  logic [TIM_W-1:0]        cfg_t_burst_min_i,
  input  logic [TIM_W-1:0]        cfg_t_burst_max_i,
  input  logic [TIM_W-1:0]        cfg_t_ccd_l_i,
  input  logic [TIM_W-1:0]        cfg_t_cl_i,
  input  logic [TIM_W-1:0]        cfg_t_wtr_i,
  input  logic [TIM_W-1:0]        cfg_t_wtr_l_i,
  input  logic [TIM_W-1:0]        cfg_t_rtw_i,
  input  logic                    cmd_valid_i,
  input  logic                    cmd_is_read_i,
  input  logic [BG_W-1:0]         cmd_bank_group_i,
  input  logic [CYC_W-1:0]        cmd_req_cycle_i,
  output logic                    issue_valid_o,
  output logic [CYC_W-1:0]        issue_cycle_o,
  output logic [CYC_W-1:0]        ready_cycle_o,
  output logic [CYC_W-1:0]        next_burst_o,
  output logic [NUM_BG*CYC_W-1:0] rd_allowed_o,
  output logic [NUM_BG*CYC_W-1:0] wr_allowed_o
);
  logic [CYC_W-1:0] rd_allowed [NUM_BG];
  logic [CYC_W-1:0] wr_allowed [NUM_BG];
  logic [CYC_W-1:0] col_allowed;
  logic [CYC_W-1:0] cmd_at, gap;
  logic [CYC_W-1:0] same_rd, same_wr, diff_rd, diff_wr;
  logic [CYC_W-1:0] last_burst_q, next_burst_q, issue_q, ready_q;
  logic             have_last_q, issue_vld_q;
  dir_e             dir;

  assign dir = cmd_is_read_i ? DIR_RD : DIR_WR;

  always_comb begin
    col_allowed = '0;
    for (int g = 0; g < NUM_BG; g++) begin
      if (BG_W'(g) == cmd_bank_group_i)
        col_allowed = (dir == DIR_RD) ? rd_allowed[g] : wr_allowed[g];
    end
  end

  ilv_slot_pick #(.CYC_W(CYC_W), .TIM_W(TIM_W)) u_pick (
    .req_cycle_i   (cmd_req_cycle_i),
    .col_allowed_i (col_allowed),
    .next_burst_i  (next_burst_q),
    .last_burst_i  (last_burst_q),
    .have_last_i   (have_last_q),
    .t_burst_i     (cfg_t_burst_i),
    .t_burst_min_i (cfg_t_burst_min_i),
    .cmd_at_o      (cmd_at),
    .gap_o         (gap)
  );

  ilv_turn_calc #(.CYC_W(CYC_W), .TIM_W(TIM_W)) u_turn (
    .dir_i         (dir),
    .gap_i         (gap),
    .t_burst_i     (cfg_t_burst_i),
    .t_burst_max_i (cfg_t_burst_max_i),
    .t_ccd_l_i     (cfg_t_ccd_l_i),
    .t_cl_i        (cfg_t_cl_i),
    .t_wtr_i       (cfg_t_wtr_i),
    .t_wtr_l_i     (cfg_t_wtr_l_i),
    .t_rtw_i       (cfg_t_rtw_i),
    .same_rd_o     (same_rd),
    .same_wr_o     (same_wr),
    .diff_rd_o     (diff_rd),
    .diff_wr_o     (diff_wr)
  );

  for (genvar g = 0; g < NUM_BG; g++) begin : g_bg
    ilv_bg_timer #(.CYC_W(CYC_W)) u_timer (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .upd_i        (cmd_valid_i),
      .same_i       (cmd_bank_group_i == BG_W'(g)),
      .cmd_at_i     (cmd_at),
      .same_rd_i    (same_rd),
      .same_wr_i    (same_wr),
      .diff_rd_i    (diff_rd),
      .diff_wr_i    (diff_wr),
      .rd_allowed_o (rd_allowed[g]),
      .wr_allowed_o (wr_allowed[g])
    );
    assign rd_allowed_o[g*CYC_W +: CYC_W] = rd_allowed[g];
    assign wr_allowed_o[g*CYC_W +: CYC_W] = wr_allowed[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_burst_q <= '0;
      next_burst_q <= '0;
      issue_q      <= '0;
      ready_q      <= '0;
      have_last_q  <= 1'b0;
      issue_vld_q  <= 1'b0;
    end else begin
      issue_vld_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        last_burst_q <= cmd_at;
        next_burst_q <= cmd_at + gap;
        issue_q      <= cmd_at;
        ready_q      <= cmd_at + CYC_W'(cfg_t_cl_i) + CYC_W'(cfg_t_burst_i);
        have_last_q  <= 1'b1;
      end
    end
  end

  assign issue_valid_o = issue_vld_q;
  assign issue_cycle_o = issue_q;
  assign ready_cycle_o = ready_q;
  assign next_burst_o  = next_burst_q;
endmodule

// File: rtl/ilv_sched_chk.sv
module ilv_sched_chk #(
  parameter int CYC_W  = 32,
  parameter int TIM_W  = 8,
  parameter int NUM_BG = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cmd_valid_i,
  input logic [CYC_W-1:0]        cmd_req_cycle_i,
  input logic [TIM_W-1:0]        cfg_t_burst_i,
  input logic [TIM_W-1:0]        cfg_t_burst_min_i,
  input logic [TIM_W-1:0]        cfg_t_cl_i,
  input logic                    issue_valid_o,
  input logic [CYC_W-1:0]        issue_cycle_o,
  input logic [CYC_W-1:0]        ready_cycle_o,
  input logic [CYC_W-1:0]        next_burst_o,
  input logic [NUM_BG*CYC_W-1:0] rd_allowed_o,
  input logic [NUM_BG*CYC_W-1:0] wr_allowed_o
);
  logic [CYC_W-1:0] prev_q;
  logic             seen_q;
  logic [CYC_W-1:0] t_min, t_full, t_lat;
  logic             ilv;

  assign t_min  = CYC_W'(cfg_t_burst_min_i);
  assign t_full = CYC_W'(cfg_t_burst_i);
  assign t_lat  = CYC_W'(cfg_t_cl_i) + CYC_W'(cfg_t_burst_i);
  assign ilv    = (cfg_t_burst_i != cfg_t_burst_min_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (issue_valid_o) begin
      prev_q <= issue_cycle_o;
      seen_q <= 1'b1;
    end
  end

  a_r2_valid_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> $past(cmd_valid_i));

  a_r2_not_before_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> issue_cycle_o >= $past(cmd_req_cycle_i));

  a_r7_ready_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ready_cycle_o == issue_cycle_o + t_lat);

  a_r7_gap_choice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (next_burst_o == issue_cycle_o + t_min) ||
                      (next_burst_o == issue_cycle_o + t_full));

  a_r4_no_double_hole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && seen_q && ilv && issue_cycle_o == prev_q + t_min)
      |-> next_burst_o == issue_cycle_o + t_full);

  a_r5_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && seen_q && ilv)
      |-> (issue_cycle_o == prev_q + t_min) || (issue_cycle_o >= prev_q + t_full));

  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !issue_valid_o && $stable(next_burst_o) && $stable(issue_cycle_o));

  for (genvar g = 0; g < NUM_BG; g++) begin : g_mono
    a_r10_rd_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_allowed_o[g*CYC_W +: CYC_W] >= $past(rd_allowed_o[g*CYC_W +: CYC_W]));
    a_r10_wr_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_allowed_o[g*CYC_W +: CYC_W] >= $past(wr_allowed_o[g*CYC_W +: CYC_W]));
  end
endmodule

bind ilv_sched ilv_sched_chk #(.CYC_W(CYC_W), .TIM_W(TIM_W), .NUM_BG(NUM_BG)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cmd_valid_i       (cmd_valid_i),
  .cmd_req_cycle_i   (cmd_req_cycle_i),
  .cfg_t_burst_i     (cfg_t_burst_i),
  .cfg_t_burst_min_i (cfg_t_burst_min_i),
  .cfg_t_cl_i        (cfg_t_cl_i),
  .issue_valid_o     (issue_valid_o),
  .issue_cycle_o     (issue_cycle_o),
  .ready_cycle_o     (ready_cycle_o),
  .next_burst_o      (next_burst_o),
  .rd_allowed_o      (rd_allowed_o),
  .wr_allowed_o      (wr_allowed_o)
);

// File: tb/tb_ilv_sched.sv
module tb_ilv_sched;
  localparam int CW = 32;
  localparam int TW = 8;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] t_burst, t_min, t_max, t_ccd, t_cl, t_wtr, t_wtrl, t_rtw;
  logic cmd_v = 1'b0, cmd_rd = 1'b0;
  logic [1:0] cmd_bg = '0;
  logic [CW-1:0] cmd_req = '0;
  logic iss_v;
  logic [CW-1:0] iss_c, rdy_c, nxt_c;
  logic [NB*CW-1:0] rd_al, wr_al;

  always #2 clk = ~clk;

  ilv_sched #(.CYC_W(CW), .TIM_W(TW), .NUM_BG(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_t_burst_i(t_burst), .cfg_t_burst_min_i(t_min), .cfg_t_burst_max_i(t_max),
    .cfg_t_ccd_l_i(t_ccd), .cfg_t_cl_i(t_cl), .cfg_t_wtr_i(t_wtr),
    .cfg_t_wtr_l_i(t_wtrl), .cfg_t_rtw_i(t_rtw),
    .cmd_valid_i(cmd_v), .cmd_is_read_i(cmd_rd), .cmd_bank_group_i(cmd_bg),
    .cmd_req_cycle_i(cmd_req),
    .issue_valid_o(iss_v), .issue_cycle_o(iss_c), .ready_cycle_o(rdy_c),
    .next_burst_o(nxt_c), .rd_allowed_o(rd_al), .wr_allowed_o(wr_al)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_last, m_next, m_issue, m_ready, m_bg;
  int m_rd[NB], m_wr[NB];
  bit m_have, m_valid;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_last = 0; m_next = 0; m_issue = 0; m_ready = 0; m_have = 0; m_valid = 0; m_bg = 0;
    for (int g = 0; g < NB; g++) begin m_rd[g] = 0; m_wr[g] = 0; end
  endtask

  task automatic model_step(bit v, bit rd, int bg, int req);
    int base, at, gap, drd, dwr;
    m_valid = v;
    if (!v) return;
    base = mx(mx(rd ? m_rd[bg] : m_wr[bg], m_next), req);
    at = base; gap = t_min;
    if (t_burst != t_min && m_have) begin
      if (base == m_last + t_min) gap = t_burst;
      else if (base < m_last + t_burst) at = m_last + t_burst;
    end
    for (int g = 0; g < NB; g++) begin
      if (g == bg) begin
        drd = rd ? t_ccd : mx(t_ccd, t_cl + t_max + t_wtrl);
        dwr = rd ? mx(t_ccd, t_rtw + t_max) : t_ccd;
      end else begin
        drd = rd ? gap : t_cl + t_burst + t_wtr;
        dwr = rd ? t_rtw + t_burst : gap;
      end
      m_rd[g] = mx(m_rd[g], at + drd);
      m_wr[g] = mx(m_wr[g], at + dwr);
    end
    m_last = at; m_have = 1; m_next = at + gap; m_issue = at;
    m_ready = at + t_cl + t_burst; m_bg = bg;
  endtask

  task automatic compare(string itag);
    chk(m_valid ? "R2" : "R11", "issue_valid", int'(iss_v), int'(m_valid));
    chk(itag, "issue_cycle", int'(iss_c), m_issue);
    chk("R7", "ready_cycle", int'(rdy_c), m_ready);
    chk("R7", "next_burst", int'(nxt_c), m_next);
    for (int g = 0; g < NB; g++) begin
      chk((g == m_bg) ? "R8" : "R9", $sformatf("rd_allowed[%0d]", g),
          int'(rd_al[g*CW +: CW]), m_rd[g]);
      chk((g == m_bg) ? "R8" : "R9", $sformatf("wr_allowed[%0d]", g),
          int'(wr_al[g*CW +: CW]), m_wr[g]);
    end
  endtask

  task automatic step(bit v, bit rd, int bg, int req, string itag);
    @(negedge clk);
    cmd_v = v; cmd_rd = rd; cmd_bg = 2'(bg); cmd_req = CW'(req);
    model_step(v, rd, bg, req);
    @(posedge clk);
    #1;
    compare(itag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_v = 0;
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(0, 3) != 0);
      step(v, 1'($urandom_range(0, 1)), $urandom_range(0, NB - 1),
           m_last + $urandom_range(0, 12), "R2");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_burst = 6; t_min = 2; t_max = 8; t_ccd = 8; t_cl = 10; t_wtr = 3; t_wtrl = 5; t_rtw = 1;
    model_reset();
    #1;
    // R1: outputs under reset
    chk("R1", "issue_valid in reset", int'(iss_v), 0);
    chk("R1", "next_burst in reset", int'(nxt_c), 0);
    chk("R1", "rd_allowed in reset", int'(rd_al != '0), 0);
    do_reset();
    @(posedge clk); #1;
    chk("R1", "issue_cycle after reset", int'(iss_c), 0);
    chk("R1", "wr_allowed after reset", int'(wr_al != '0), 0);

    // R6: first command, candidate 3 below phantom 0+6, not moved
    step(1, 1, 0, 3, "R6");
    chk("R6", "first issue", int'(iss_c), 3);
    chk("R6", "first gap", int'(nxt_c), 5);
    chk("R8", "same bg read->write", int'(wr_al[0 +: CW]), 12);
    chk("R9", "other bg read->read", int'(rd_al[CW +: CW]), 5);
    chk("R9", "other bg read->write", int'(wr_al[CW +: CW]), 10);
    // R4: lands in the hole at 3+2, gap becomes full
    step(1, 1, 1, 0, "R4");
    chk("R4", "hole issue", int'(iss_c), 5);
    chk("R4", "full gap after hole", int'(nxt_c), 11);
    // follow-on read to bg2 at 11, not off-boundary
    step(1, 1, 2, 0, "R2");
    chk("R2", "issue at next burst", int'(iss_c), 11);
    chk("R7", "ready", int'(rdy_c), 27);
    // R11: idle cycle keeps everything
    step(0, 0, 3, 99, "R11");
    chk("R11", "idle issue_valid", int'(iss_v), 0);
    chk("R11", "idle next_burst", int'(nxt_c), 13);
    // R5: candidate 14 inside 11..17 and not the hole -> snapped to 17
    step(1, 1, 3, 14, "R5");
    chk("R5", "snapped issue", int'(iss_c), 17);
    chk("R5", "short gap after snap", int'(nxt_c), 19);
    // write to same bg after read: R8 write-to-read penalty
    step(1, 0, 3, 40, "R8");
    chk("R8", "same bg write->read", int'(rd_al[3*CW +: CW]), 40 + 23);
    chk("R9", "other bg write->read", int'(rd_al[0 +: CW]), 40 + 19);
    random_run(500);

    // R3: equal nominal and minimum spacing, no interleave rules
    t_min = 6;
    do_reset();
    step(1, 1, 0, 3, "R3");
    step(1, 1, 1, 0, "R3");
    chk("R3", "no hole when equal", int'(iss_c), 9);
    chk("R3", "gap equals burst", int'(nxt_c), 15);
    random_run(500);

    // bank-group heavy mix with long same-group spacing
    t_min = 2; t_ccd = 12; t_max = 10;
    do_reset();
    random_run(500);
    finish_run();
  end
endmodule